// File: doc/BRIEF.md
# DDR2 Extended Mode Register Controller

This block is the device-side view of the first extended mode register of a DDR2 memory. A load-mode command carries its value on the address bus, selected by a bank-address code. The block decodes that value and keeps these fields: the DLL switch, the reduced-strength driver select, the termination code, the additive latency and the impedance-calibration mode. It also keeps three strobe and output controls: single-ended strobe, read strobe and output disable. The drive, termination and calibration fields are only stored and brought out on ports.

The block uses the programmed strobe mode and the current data phase (read or write) to drive the output enables for data, the strobe, the complementary strobe, the read strobe and its complement, and the data-mask input enable. The device organisation is a parameter. Only the x8 organisation honours the read-strobe bit.

The block also tracks the DLL. The DLL is off while the register disables it and while the device is in self-refresh. Leaving self-refresh resets the DLL, and so does reset. After each DLL reset, read commands are refused until a relock interval of 200 cycles has passed. A refused read raises a flag for one cycle.

Top module: `ddr2_emr_ctrl`

## Requirements
- R1: A load with `ba`=3'b001 and `addr[15:13]`=0 updates the register, and the new fields show on the next cycle. `addr[0]` sets `dll_off`, `addr[1]` sets `drv_half`, `odt_code`={`addr[6]`,`addr[2]`}, `add_lat`=`addr[5:3]` and `ocd_mode`=`addr[9:7]`.
- R2: A load whose `ba[1:0]` is not 2'b01 leaves every stored field and `cfg_err` unchanged.
- R3: A load with `ba[1:0]`=2'b01 that has `ba[2]`=1 or any of `addr[15:13]` set leaves the register unchanged and sets `cfg_err`. `cfg_err` stays set until reset.
- R4: After reset all fields are zero, `cfg_err` is 0, every output enable is 0 and reads are refused.
- R5: While `rd_phase` is high and `addr[12]` was stored 0, `dq_oe` and `dqs_oe` are 1 and `dqs_n_oe` equals NOT of the stored `addr[10]`. With no data phase active, all output enables are 0.
- R6: On x8, a stored `addr[11]`=1 gives `rdqs_oe`=1 during reads, with `rdqs_n_oe` = NOT stored `addr[10]`. In that mode both read-strobe enables are 0 during writes and `dm_en` is 0. When `addr[11]`=0, `dm_en` is 1 during a write phase.
- R7: A stored `addr[12]`=1 forces all five output enables to 0 even during reads.
- R8: After reset, a read is accepted no earlier than 200 clock edges later. It is refused after 199 edges and accepted after 200.
- R9: A self-refresh entry turns the DLL off and refuses reads. An exit restarts the 200-edge relock interval.
- R10: A stored `addr[0]`=1 lowers `dll_on` and refuses reads. Clearing it again allows reads once the relock interval has run.
- R11: A refused read sets `read_blocked` on the next cycle for exactly one cycle.
- R12: On x4 and x16, `addr[11]` is stored but `rdqs_oe` stays 0 and `dm_en` still follows the write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_mode | input | 1 | Load-mode command strobe |
| ba | input | 3 | Bank address with the command |
| addr | input | ADDR_W | Address bus carrying the register value |
| rd_cmd | input | 1 | Read command issued this cycle |
| rd_phase | input | 1 | Read data phase in progress |
| wr_phase | input | 1 | Write data phase in progress |
| sref_enter | input | 1 | Self-refresh entry |
| sref_exit | input | 1 | Self-refresh exit |
| dll_off | output | 1 | Stored DLL disable bit |
| drv_half | output | 1 | Stored reduced-strength select |
| odt_code | output | 2 | Stored termination code |
| add_lat | output | 3 | Stored additive latency |
| ocd_mode | output | 3 | Stored calibration mode |
| cfg_err | output | 1 | Sticky reserved-bit error |
| dq_oe | output | 1 | Data output enable |
| dqs_oe | output | 1 | Strobe output enable |
| dqs_n_oe | output | 1 | Complementary strobe output enable |
| rdqs_oe | output | 1 | Read strobe output enable |
| rdqs_n_oe | output | 1 | Complementary read strobe output enable |
| dm_en | output | 1 | Data-mask input enable |
| dll_on | output | 1 | DLL currently running |
| dll_locked | output | 1 | DLL running and relock interval done |
| read_accept | output | 1 | Current read command accepted |
| read_blocked | output | 1 | One-cycle flag after a refused read |

## Verification
The bench probes the relock edge exactly: a read at 199 edges must be refused and a read at 200 accepted. An off-by-one counter fails one of these two probes. It repeats the probe after a self-refresh exit, which catches a design that resets the count only at reset. Reserved-bit writes, sent through both `ba[2]` and `addr[13]`, must leave the fields intact and keep the error set across a later valid load; a design that stored the value anyway or cleared the error would show it on the field ports. A second instance built as x16 receives the same read-strobe setting, so an organisation check that was missed would show up as a read-strobe enable or a lost data mask.

// File: rtl/ddr2_emr_pkg.sv
package ddr2_emr_pkg;

    typedef struct packed {
        logic       qoff;
        logic       rdqs_on;
        logic       dqs_single;
        logic [2:0] ocd;
        logic [2:0] al;
        logic [1:0] odt;
        logic       drv_half;
        logic       dll_off;
    } emr_cfg_t;

    localparam int unsigned EMR_FIELD_W = 13;

    function automatic emr_cfg_t emr_decode(input logic [EMR_FIELD_W-1:0] a);
        emr_cfg_t c;
        c.dll_off    = a[0];
        c.drv_half   = a[1];
        c.odt        = {a[6], a[2]};
        c.al         = a[5:3];
        c.ocd        = a[9:7];
        c.dqs_single = a[10];
        c.rdqs_on    = a[11];
        c.qoff       = a[12];
        return c;
    endfunction

endpackage

// File: rtl/emr_regfile.sv
module emr_regfile
    import ddr2_emr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_mode,
    input  logic [2:0]        ba,
    input  logic [ADDR_W-1:0] addr,
    output emr_cfg_t          cfg,
    output logic              cfg_err
);

    localparam int unsigned RSV_W = ADDR_W - EMR_FIELD_W;

    typedef struct packed {
        emr_cfg_t cfg;
        logic     err;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic      hit;
    logic      bad;

    always_comb begin
        st_d = st_q;
        hit  = ld_mode && (ba[1:0] == 2'b01);
        bad  = ba[2] || (|addr[ADDR_W-1 -: RSV_W]);
        if (hit) begin
            if (bad) begin
                st_d.err = 1'b1;
            end else begin
                st_d.cfg = emr_decode(addr[EMR_FIELD_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg     = st_q.cfg;
    assign cfg_err = st_q.err;

    assert_load_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !bad) |=> (cfg == emr_decode($past(addr[EMR_FIELD_W-1:0]))));

    assert_other_bank_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mode && ba[1:0] != 2'b01) |=> ($stable(cfg) && $stable(cfg_err)));

    assert_reserved_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bad) |=> ($stable(cfg) && cfg_err));

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

endmodule

// File: rtl/emr_strobe_oe.sv
module emr_strobe_oe
    import ddr2_emr_pkg::*;
#(
    parameter int unsigned ORG = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  emr_cfg_t cfg,
    input  logic     rd_phase,
    input  logic     wr_phase,
    output logic     dq_oe,
    output logic     dqs_oe,
    output logic     dqs_n_oe,
    output logic     rdqs_oe,
    output logic     rdqs_n_oe,
    output logic     dm_en
);

    logic rdqs_eff;
    logic drive_rd;
    logic wr_only;

    generate
        if (ORG == 8) begin : g_rdqs_capable
            assign rdqs_eff = cfg.rdqs_on;
        end else begin : g_no_rdqs
            assign rdqs_eff = 1'b0;
            assert_no_rdqs_org_R12: assert property (@(posedge clk) disable iff (!rst_n)
                (!rdqs_oe && !rdqs_n_oe));
        end
    endgenerate

    always_comb begin
        drive_rd  = rd_phase && !cfg.qoff;
        wr_only   = wr_phase && !rd_phase;
        dq_oe     = drive_rd;
        dqs_oe    = drive_rd;
        dqs_n_oe  = drive_rd && !cfg.dqs_single;
        rdqs_oe   = drive_rd && rdqs_eff;
        rdqs_n_oe = drive_rd && rdqs_eff && !cfg.dqs_single;
        dm_en     = wr_only && !rdqs_eff;
    end

    assert_rdqs_quiet_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_phase && !rd_phase) |-> (!rdqs_oe && !rdqs_n_oe));

    assert_dm_rdqs_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(dm_en && rdqs_oe));

    assert_qoff_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.qoff |-> !(dq_oe || dqs_oe || dqs_n_oe || rdqs_oe || rdqs_n_oe));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_phase && !wr_phase) |-> !(dq_oe || dqs_oe || dqs_n_oe || rdqs_oe || dm_en));

endmodule

// File: rtl/emr_dll_lock.sv
module emr_dll_lock #(
    parameter int unsigned RELOCK_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dll_off,
    input  logic sref_enter,
    input  logic sref_exit,
    input  logic rd_cmd,
    output logic dll_on,
    output logic dll_locked,
    output logic read_accept,
    output logic read_blocked
);

    localparam int unsigned CNT_W = $clog2(RELOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RELOCK_CYCLES);

    typedef struct packed {
        logic             in_sref;
        logic [CNT_W-1:0] cnt;
        logic             blocked;
    } dll_state_t;

    dll_state_t st_d, st_q;
    logic       leave;
    logic       enter;

    always_comb begin
        st_d  = st_q;
        enter = sref_enter && !st_q.in_sref;
        leave = sref_exit && st_q.in_sref;
        if (enter) st_d.in_sref = 1'b1;
        if (leave) st_d.in_sref = 1'b0;
        if (st_q.in_sref || leave) begin
            st_d.cnt = CNT_FULL;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        dll_on       = !dll_off && !st_q.in_sref;
        dll_locked   = dll_on && (st_q.cnt == '0);
        read_accept  = rd_cmd && dll_locked;
        st_d.blocked = rd_cmd && !dll_locked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{in_sref: 1'b0, cnt: CNT_FULL, blocked: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign read_blocked = st_q.blocked;

    assert_relock_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sref_exit && st_q.in_sref) |=> (st_q.cnt == CNT_FULL && !dll_locked));

    assert_sref_dll_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.in_sref |-> (!dll_on && !read_accept));

    assert_dll_off_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dll_off |-> !read_accept);

    assert_blocked_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        read_blocked |-> $past(rd_cmd));

    assert_relock_not_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |-> !read_accept);

endmodule

// File: rtl/ddr2_emr_ctrl.sv
module ddr2_emr_ctrl
    import ddr2_emr_pkg::*;
#(
    parameter int unsigned ORG           = 8,
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned RELOCK_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_mode,
    input  logic [2:0]        ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_cmd,
    input  logic              rd_phase,
    input  logic              wr_phase,
    input  logic              sref_enter,
    input  logic              sref_exit,
    output logic              dll_off,
    output logic              drv_half,
    output logic [1:0]        odt_code,
    output logic [2:0]        add_lat,
    output logic [2:0]        ocd_mode,
    output logic              cfg_err,
    output logic              dq_oe,
    output logic              dqs_oe,
    output logic              dqs_n_oe,
    output logic              rdqs_oe,
    output logic              rdqs_n_oe,
    output logic              dm_en,
    output logic              dll_on,
    output logic              dll_locked,
    output logic              read_accept,
    output logic              read_blocked
);

    emr_cfg_t cfg;

    emr_regfile #(.ADDR_W(ADDR_W)) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_mode (ld_mode),
        .ba      (ba),
        .addr    (addr),
        .cfg     (cfg),
        .cfg_err (cfg_err)
    );

    emr_strobe_oe #(.ORG(ORG)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .rd_phase  (rd_phase),
        .wr_phase  (wr_phase),
        .dq_oe     (dq_oe),
        .dqs_oe    (dqs_oe),
        .dqs_n_oe  (dqs_n_oe),
        .rdqs_oe   (rdqs_oe),
        .rdqs_n_oe (rdqs_n_oe),
        .dm_en     (dm_en)
    );

    emr_dll_lock #(.RELOCK_CYCLES(RELOCK_CYCLES)) u_dll (
        .clk          (clk),
        .rst_n        (rst_n),
        .dll_off      (cfg.dll_off),
        .sref_enter   (sref_enter),
        .sref_exit    (sref_exit),
        .rd_cmd       (rd_cmd),
        .dll_on       (dll_on),
        .dll_locked   (dll_locked),
        .read_accept  (read_accept),
        .read_blocked (read_blocked)
    );

    assign dll_off  = cfg.dll_off;
    assign drv_half = cfg.drv_half;
    assign odt_code = cfg.odt;
    assign add_lat  = cfg.al;
    assign ocd_mode = cfg.ocd;

    assert_read_needs_dll_R10: assert property (@(posedge clk) disable iff (!rst_n)
        read_accept |-> (dll_on && !dll_off));

endmodule

// File: tb/ddr2_emr_ctrl_tb.sv
module ddr2_emr_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_mode = 1'b0;
    logic [2:0]  ba = '0;
    logic [15:0] addr = '0;
    logic        rd_cmd = 1'b0;
    logic        rd_phase = 1'b0;
    logic        wr_phase = 1'b0;
    logic        sref_enter = 1'b0;
    logic        sref_exit = 1'b0;

    logic dll_off, drv_half, cfg_err, dq_oe, dqs_oe, dqs_n_oe, rdqs_oe, rdqs_n_oe, dm_en;
    logic dll_on, dll_locked, read_accept, read_blocked;
    logic [1:0] odt_code;
    logic [2:0] add_lat, ocd_mode;

    logic x_dll_off, x_drv_half, x_cfg_err, x_dq_oe, x_dqs_oe, x_dqs_n_oe, x_rdqs_oe, x_rdqs_n_oe, x_dm_en;
    logic x_dll_on, x_dll_locked, x_read_accept, x_read_blocked;
    logic [1:0] x_odt_code;
    logic [2:0] x_add_lat, x_ocd_mode;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ddr2_emr_ctrl #(.ORG(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_mode(ld_mode), .ba(ba), .addr(addr),
        .rd_cmd(rd_cmd), .rd_phase(rd_phase), .wr_phase(wr_phase),
        .sref_enter(sref_enter), .sref_exit(sref_exit),
        .dll_off(dll_off), .drv_half(drv_half), .odt_code(odt_code), .add_lat(add_lat),
        .ocd_mode(ocd_mode), .cfg_err(cfg_err), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
        .dqs_n_oe(dqs_n_oe), .rdqs_oe(rdqs_oe), .rdqs_n_oe(rdqs_n_oe), .dm_en(dm_en),
        .dll_on(dll_on), .dll_locked(dll_locked), .read_accept(read_accept),
        .read_blocked(read_blocked)
    );

    ddr2_emr_ctrl #(.ORG(16)) dut_x16_i (
        .clk(clk), .rst_n(rst_n), .ld_mode(ld_mode), .ba(ba), .addr(addr),
        .rd_cmd(rd_cmd), .rd_phase(rd_phase), .wr_phase(wr_phase),
        .sref_enter(sref_enter), .sref_exit(sref_exit),
        .dll_off(x_dll_off), .drv_half(x_drv_half), .odt_code(x_odt_code), .add_lat(x_add_lat),
        .ocd_mode(x_ocd_mode), .cfg_err(x_cfg_err), .dq_oe(x_dq_oe), .dqs_oe(x_dqs_oe),
        .dqs_n_oe(x_dqs_n_oe), .rdqs_oe(x_rdqs_oe), .rdqs_n_oe(x_rdqs_n_oe), .dm_en(x_dm_en),
        .dll_on(x_dll_on), .dll_locked(x_dll_locked), .read_accept(x_read_accept),
        .read_blocked(x_read_blocked)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_load(input logic [2:0] b, input logic [15:0] a);
        ld_mode = 1'b1;
        ba = b;
        addr = a;
        tick();
        ld_mode = 1'b0;
        ba = '0;
        addr = '0;
        settle();
    endtask

    task automatic set_phase(input logic r, input logic w);
        rd_phase = r;
        wr_phase = w;
        settle();
    endtask

    // R4, R11, R8: reset state, refused read flag, relock boundary at 199/200 edges
    task automatic t_reset_and_relock();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        rd_cmd = 1'b1;
        settle();
        chk("R4 fields zero", {dll_off, drv_half, odt_code, add_lat, ocd_mode}, 0);
        chk("R4 cfg_err", cfg_err, 0);
        chk("R4 enables off", {dq_oe, dqs_oe, dqs_n_oe, rdqs_oe, rdqs_n_oe, dm_en}, 0);
        chk("R4 read refused", read_accept, 0);
        tick();
        rd_cmd = 1'b0;
        settle();
        chk("R11 blocked raised", read_blocked, 1);
        tick();
        settle();
        chk("R11 blocked one cycle", read_blocked, 0);
        repeat (197) tick();
        rd_cmd = 1'b1;
        settle();
        chk("R8 refused at 199 edges", read_accept, 0);
        tick();
        settle();
        chk("R8 accepted at 200 edges", read_accept, 1);
        rd_cmd = 1'b0;
        tick();
    endtask

    // R1: field decode, two patterns
    task automatic t_fields();
        do_load(3'b001, 16'h03AE);
        chk("R1 drv_half", drv_half, 1);
        chk("R1 odt_code", odt_code, 2'b01);
        chk("R1 add_lat", add_lat, 5);
        chk("R1 ocd_mode", ocd_mode, 7);
        chk("R1 dll_off", dll_off, 0);
        do_load(3'b001, 16'h0050);
        chk("R1 odt_code p2", odt_code, 2'b10);
        chk("R1 add_lat p2", add_lat, 2);
        chk("R1 drv_half p2", drv_half, 0);
        chk("R1 ocd_mode p2", ocd_mode, 0);
    endtask

    // R2: other bank codes ignored
    task automatic t_other_bank();
        do_load(3'b000, 16'h03AE);
        chk("R2 bank 000 ignored", {drv_half, odt_code, add_lat, ocd_mode}, {1'b0, 2'b10, 3'd2, 3'd0});
        do_load(3'b011, 16'h03AF);
        chk("R2 bank 011 ignored", {dll_off, drv_half, odt_code, add_lat, ocd_mode}, {1'b0, 1'b0, 2'b10, 3'd2, 3'd0});
        chk("R2 no error", cfg_err, 0);
    endtask

    // R5, R6, R12: strobe enables by mode and phase
    task automatic t_strobes();
        do_load(3'b001, 16'h0000);
        set_phase(1'b0, 1'b0);
        chk("R5 idle quiet", {dq_oe, dqs_oe, dqs_n_oe, rdqs_oe, rdqs_n_oe, dm_en}, 0);
        set_phase(1'b1, 1'b0);
        chk("R5 diff read", {dq_oe, dqs_oe, dqs_n_oe, rdqs_oe, rdqs_n_oe}, 5'b11100);
        set_phase(1'b0, 1'b1);
        chk("R6 dm on write", {dm_en, rdqs_oe}, 2'b10);
        set_phase(1'b0, 1'b0);
        do_load(3'b001, 16'h0400);
        set_phase(1'b1, 1'b0);
        chk("R5 single-ended read", {dq_oe, dqs_oe, dqs_n_oe}, 3'b110);
        set_phase(1'b0, 1'b0);
        do_load(3'b001, 16'h0800);
        set_phase(1'b1, 1'b0);
        chk("R6 rdqs diff read", {rdqs_oe, rdqs_n_oe, dqs_n_oe}, 3'b111);
        chk("R12 x16 no rdqs read", {x_rdqs_oe, x_rdqs_n_oe}, 2'b00);
        set_phase(1'b0, 1'b1);
        chk("R6 rdqs ignored on write", {rdqs_oe, rdqs_n_oe, dm_en}, 3'b000);
        chk("R12 x16 dm kept", x_dm_en, 1);
        set_phase(1'b0, 1'b0);
        do_load(3'b001, 16'h0C00);
        set_phase(1'b1, 1'b0);
        chk("R6 rdqs single-ended", {rdqs_oe, rdqs_n_oe}, 2'b10);
        set_phase(1'b0, 1'b0);
    endtask

    // R7: output disable
    task automatic t_qoff();
        do_load(3'b001, 16'h1800);
        set_phase(1'b1, 1'b0);
        chk("R7 qoff all hiz", {dq_oe, dqs_oe, dqs_n_oe, rdqs_oe, rdqs_n_oe}, 0);
        chk("R7 qoff x16 hiz", {x_dq_oe, x_dqs_oe, x_dqs_n_oe}, 0);
        set_phase(1'b0, 1'b0);
        do_load(3'b001, 16'h0000);
    endtask

    // R10: DLL disable bit
    task automatic t_dll_disable();
        do_load(3'b001, 16'h0001);
        rd_cmd = 1'b1;
        settle();
        chk("R10 dll_on low", dll_on, 0);
        chk("R10 read refused", read_accept, 0);
        rd_cmd = 1'b0;
        do_load(3'b001, 16'h0000);
        rd_cmd = 1'b1;
        settle();
        chk("R10 read after re-enable", read_accept, 1);
        rd_cmd = 1'b0;
        tick();
    endtask

    // R9: self-refresh entry/exit restarts relock
    task automatic t_sref();
        sref_enter = 1'b1;
        tick();
        sref_enter = 1'b0;
        rd_cmd = 1'b1;
        settle();
        chk("R9 dll off in sref", dll_on, 0);
        chk("R9 read refused in sref", read_accept, 0);
        rd_cmd = 1'b0;
        repeat (5) tick();
        sref_exit = 1'b1;
        tick();
        sref_exit = 1'b0;
        settle();
        chk("R9 dll back on", dll_on, 1);
        repeat (199) tick();
        rd_cmd = 1'b1;
        settle();
        chk("R9 refused at 199 after exit", read_accept, 0);
        tick();
        settle();
        chk("R9 accepted at 200 after exit", read_accept, 1);
        rd_cmd = 1'b0;
        tick();
    endtask

    // R3: reserved bits
    task automatic t_reserved();
        do_load(3'b001, 16'h0050);
        do_load(3'b101, 16'h03AE);
        chk("R3 ba2 sets err", cfg_err, 1);
        chk("R3 ba2 fields kept", {drv_half, odt_code, add_lat, ocd_mode}, {1'b0, 2'b10, 3'd2, 3'd0});
        do_load(3'b001, 16'h23AE);
        chk("R3 addr13 fields kept", {drv_half, odt_code, add_lat, ocd_mode}, {1'b0, 2'b10, 3'd2, 3'd0});
        do_load(3'b001, 16'h03AE);
        chk("R3 err sticky", cfg_err, 1);
        chk("R3 valid load still applies", add_lat, 5);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        @(negedge clk);
        t_reset_and_relock();
        t_fields();
        t_other_bank();
        t_strobes();
        t_qoff();
        t_dll_disable();
        t_sref();
        t_reserved();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule